// File: doc/BRIEF.md
# Nine-Bit Serial Command Writer

This block sends register commands and their parameter bytes to a display controller. The link is write-only and serial, and each word on it is nine bits long. The top bit of every word is a flag that marks the word as a command or as data. The eight payload bits follow it, most significant bit first.

A single request carries an 8-bit register address and zero, one or two parameter bytes. The block wraps the command word and the data words in one chip-select frame. It leaves no gap between the words. When the frame is over it raises a one-cycle completion pulse.

The serial clock is derived from the system clock by a divider parameter. The link uses SPI mode 3: the clock idles high, data changes on the falling edge and the receiver samples it on the rising edge.

Top module: `ninebit_cmd_tx`

## Requirements
- R1: After reset the block is idle: `spi_csn` high, `spi_sclk` high, `busy` low, `done` low.
- R2: Each word is 9 bits, shifted most significant bit first and sampled on the rising `spi_sclk` edge. Bit 8 is 0 for the command word and 1 for every data word, and bits 7:0 carry the payload. The command word's payload is `req_addr`.
- R3: A frame holds one command word followed by `req_nbytes` data words, where `req_nbytes` is 0, 1 or 2.
- R4: With two data bytes, the first data word carries `req_data[15:8]` and the second carries `req_data[7:0]`. With one data byte, the single data word carries `req_data[7:0]`.
- R5: `spi_sclk` is high whenever `spi_csn` is high. While `spi_csn` is low, `spi_mosi` does not change during any cycle in which `spi_sclk` stays high.
- R6: Per accepted request, `spi_csn` falls once and rises once, and it stays low across all words of the frame.
- R7: `busy` is high from the cycle after a request is accepted (`req_valid` high while `busy` is low) until `spi_csn` rises. `done` is high for exactly one cycle: the cycle in which `spi_csn` has just risen and `busy` has fallen.
- R8: `req_valid` pulses while `busy` is high are ignored. They change neither the frame in progress nor what follows it, and no second frame starts.
- R9: Every `spi_sclk` half period lasts `HALF_DIV` system clocks. The time from `spi_csn` falling to the first falling edge is `HALF_DIV` clocks, and so is the time from the last rising edge to `spi_csn` rising. `busy` therefore stays high for `HALF_DIV*(2+18*W)` cycles for a frame of W words.
- R10: A `req_nbytes` value of 3 is sent as two data bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_addr | input | 8 | Register address carried by the command word |
| req_nbytes | input | 2 | Number of parameter bytes (0..2; 3 acts as 2) |
| req_data | input | 16 | Parameter bytes; high byte is sent first when two are present |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_csn | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |

## Verification
A wrong word counter or a wrong bit counter makes the frame come out with the wrong length. The bench sees this at the next chip-select release: extra or missing words, or a leftover partial word. A corrupt frame register shows up as a word mismatch on the very word that carries it, since each word is compared as soon as its ninth rising edge arrives.

A divider fault changes the length of the `busy` window, and that length is checked exactly at the end of every frame. A request that slips in while busy leaves one of two traces. Either the words in flight differ from the expected ones, or a second chip-select fall appears within a few cycles of `done`.

// File: rtl/n9_pkg.sv
package n9_pkg;
  localparam int WORD_W    = 9;
  localparam int BYTE_W    = 8;
  localparam int MAX_WORDS = 3;
  localparam int FRAME_W   = WORD_W * MAX_WORDS;
  localparam int BITCNT_W  = $clog2(FRAME_W + 1);

  localparam logic FLAG_CMD  = 1'b0;
  localparam logic FLAG_DATA = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_HOLD
  } tx_state_e;
endpackage

// File: rtl/n9_half_tick.sv
module n9_half_tick #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (HALF_DIV <= 1) begin : g_direct
      assign tick = run;
    end else begin : g_count
      localparam int CNT_W = $clog2(HALF_DIV);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);
      logic [CNT_W-1:0] cnt_q, cnt_d;

      always_comb begin
        cnt_d = cnt_q;
        if (!run)               cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = '0;
        else                    cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick = run && (cnt_q == LAST);

      AST_TICK_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tick);  // R9
      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);  // R9
    end
  endgenerate
endmodule

// File: rtl/n9_frame_shift.sv
module n9_frame_shift
  import n9_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] addr,
  input  logic [1:0]        nbytes,
  input  logic [15:0]       data,
  output logic              mosi
);
  logic [FRAME_W-1:0] frame_q, frame_d;
  logic [BYTE_W-1:0]  first_byte;

  // With two bytes the high byte goes first; with one byte only the low byte is sent.
  assign first_byte = (nbytes >= 2'd2) ? data[15:8] : data[7:0];

  always_comb begin
    frame_d = frame_q;
    if (load)
      frame_d = {FLAG_CMD, addr, FLAG_DATA, first_byte, FLAG_DATA, data[7:0]};
    else if (shift)
      frame_d = {frame_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frame_q <= '0;
    else        frame_q <= frame_d;
  end

  assign mosi = frame_q[FRAME_W-1];
endmodule

// File: rtl/n9_frame_seq.sv
module n9_frame_seq
  import n9_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_nbytes,
  input  logic       tick,
  output logic       run,
  output logic       load,
  output logic       shift,
  output logic       busy,
  output logic       done,
  output logic       csn,
  output logic       sclk
);
  tx_state_e           state_q, state_d;
  logic [BITCNT_W-1:0] bitcnt_q, bitcnt_d;
  logic [BITCNT_W-1:0] lastbit_q, lastbit_d;
  logic                done_q, done_d;
  logic                accept;

  assign accept = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d   = state_q;
    bitcnt_d  = bitcnt_q;
    lastbit_d = lastbit_q;
    done_d    = 1'b0;
    shift     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d  = ST_SETUP;
          bitcnt_d = '0;
          unique case (req_nbytes)
            2'd0:    lastbit_d = BITCNT_W'(WORD_W - 1);
            2'd1:    lastbit_d = BITCNT_W'(2 * WORD_W - 1);
            default: lastbit_d = BITCNT_W'(3 * WORD_W - 1);
          endcase
        end
      end
      ST_SETUP: if (tick) state_d = ST_LOW;
      ST_LOW:   if (tick) state_d = ST_HIGH;
      ST_HIGH: begin
        if (tick) begin
          if (bitcnt_q == lastbit_q) begin
            state_d = ST_HOLD;
          end else begin
            state_d  = ST_LOW;
            bitcnt_d = bitcnt_q + 1'b1;
            shift    = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (tick) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bitcnt_q  <= '0;
      lastbit_q <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      bitcnt_q  <= bitcnt_d;
      lastbit_q <= lastbit_d;
      done_q    <= done_d;
    end
  end

  assign run  = (state_q != ST_IDLE);
  assign load = accept;
  assign busy = run;
  assign csn  = !run;
  assign sclk = (state_q != ST_LOW);
  assign done = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R7
  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |=> $stable(lastbit_q));  // R8
  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bitcnt_q <= lastbit_q);  // R3
endmodule

// File: rtl/ninebit_cmd_tx.sv
module ninebit_cmd_tx
  import n9_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [7:0]  req_addr,
  input  logic [1:0]  req_nbytes,
  input  logic [15:0] req_data,
  output logic        busy,
  output logic        done,
  output logic        spi_csn,
  output logic        spi_sclk,
  output logic        spi_mosi
);
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       run, tick, load, shift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  n9_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n_s),
    .run  (run),
    .tick (tick)
  );

  n9_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_valid (req_valid),
    .req_nbytes(req_nbytes),
    .tick      (tick),
    .run       (run),
    .load      (load),
    .shift     (shift),
    .busy      (busy),
    .done      (done),
    .csn       (spi_csn),
    .sclk      (spi_sclk)
  );

  n9_frame_shift u_shift (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load  (load),
    .shift (shift),
    .addr  (req_addr),
    .nbytes(req_nbytes),
    .data  (req_data),
    .mosi  (spi_mosi)
  );

  AST_CS_RELEASE_DONE: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(spi_csn) |-> done);  // R7
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!spi_csn && spi_sclk && $past(!spi_csn && spi_sclk)) |-> $stable(spi_mosi));  // R5
endmodule

// File: tb/tb_ninebit_cmd_tx.sv
module tb_ninebit_cmd_tx;
  localparam int CLK_PERIOD = 10;
  localparam int TB_HALF    = 3;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  req_addr;
  logic [1:0]  req_nbytes;
  logic [15:0] req_data;
  logic        busy, done, spi_csn, spi_sclk, spi_mosi;

  int checks = 0;
  int errors = 0;

  logic [8:0] exp_q[$];
  logic [8:0] rx_word;
  int         rx_bits = 0;
  int         cs_falls = 0;
  int         cs_rises = 0;
  int         r5_bad = 0;
  logic       prev_hi = 1'b0;
  logic       prev_mosi = 1'b0;

  ninebit_cmd_tx #(.HALF_DIV(TB_HALF)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_nbytes(req_nbytes), .req_data(req_data), .busy(busy), .done(done),
    .spi_csn(spi_csn), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: collect a word on every rising serial clock edge inside the frame (R2, R4)
  always @(posedge spi_sclk) begin
    if (rst_n === 1'b1 && spi_csn === 1'b0) begin
      rx_word = {rx_word[7:0], spi_mosi};
      rx_bits++;
      if (rx_bits == 9) begin
        rx_bits = 0;
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 extra word", int'(rx_word), 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check(rx_word == e, "R2/R4 word", int'(rx_word), int'(e));
        end
      end
    end
  end

  always @(negedge spi_csn) if (rst_n === 1'b1) cs_falls++;
  always @(posedge spi_csn) if (rst_n === 1'b1) cs_rises++;

  // R5: clock idles high outside a frame, data steady while the clock is high
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (spi_csn && !spi_sclk) r5_bad++;
      if (!spi_csn && spi_sclk && prev_hi && spi_mosi !== prev_mosi) r5_bad++;
      prev_hi   = !spi_csn && spi_sclk;
      prev_mosi = spi_mosi;
    end
  end

  task automatic send(input logic [7:0] a, input logic [1:0] nb,
                      input logic [15:0] d, input bit rogue, input string tag);
    int words, cyc, f0, r0, b0;
    words = (nb == 2'd0) ? 1 : (nb == 2'd1) ? 2 : 3;
    exp_q.push_back({1'b0, a});
    if (words == 2) exp_q.push_back({1'b1, d[7:0]});
    if (words == 3) begin
      exp_q.push_back({1'b1, d[15:8]});
      exp_q.push_back({1'b1, d[7:0]});
    end
    f0 = cs_falls; r0 = cs_rises; b0 = r5_bad;
    @(negedge clk);
    req_addr = a; req_nbytes = nb; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R7 busy after accept", busy, 1);
    cyc = 1;
    forever begin
      @(negedge clk);
      if (rogue && cyc == 4) begin
        req_addr = 8'hFF; req_nbytes = 2'd2; req_data = 16'hDEAD; req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      if (!busy) break;
      cyc++;
    end
    check(done == 1'b1 && spi_csn == 1'b1, "R7 done at release", done, 1);
    check(cyc == TB_HALF * (2 + 18 * words), {"R9 busy length ", tag}, cyc, TB_HALF * (2 + 18 * words));
    check(exp_q.size() == 0 && rx_bits == 0, {"R3 word count ", tag}, exp_q.size(), 0);
    check(cs_falls - f0 == 1 && cs_rises - r0 == 1, "R6 one frame", cs_falls - f0, 1);
    check(r5_bad == b0, "R5 idle/hold", r5_bad - b0, 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    exp_q.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_nbytes = '0; req_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(spi_csn == 1 && spi_sclk == 1 && busy == 0 && done == 0, "R1 reset state",
          {spi_csn, spi_sclk, busy, done}, 4'b1100);

    send(8'h11, 2'd0, 16'h0000, 1'b0, "R3 no data");
    send(8'h3A, 2'd1, 16'h0060, 1'b0, "R2 one byte");
    send(8'hB8, 2'd2, 16'hFFF9, 1'b0, "R4 two bytes");
    send(8'hC7, 2'd2, 16'h5533, 1'b0, "R4 second pattern");
    send(8'hC5, 2'd3, 16'h1020, 1'b0, "R10 nbytes three");
    send(8'h29, 2'd1, 16'h00AB, 1'b1, "R8 ignored request");
    repeat (3) @(negedge clk);
    check(busy == 0 && spi_csn == 1, "R8 no frame after ignored request", busy, 0);
    send(8'h00, 2'd0, 16'h0000, 1'b0, "R2 zero command");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule